// File: doc/BRIEF.md
# Serial Register Port with Pipelined Reads

This block lets an external SPI master reach a small file of 16-bit registers. The master sends 16-bit frames in SPI mode 3, MSB first. Each frame is either a one-byte write or a register read. A read is answered one frame later: the word named in frame *n* is shifted out on MISO during frame *n+1*. Writes change a single byte. Reads always return the whole 16-bit word, whichever of its two byte addresses the read frame names.

Sensor logic loads the read-only output words through a parallel strobe and data bus. Each output word carries three fields:

- a new-data flag, set while the value has not yet been read;
- an error flag, which mirrors the OR of the diagnostic inputs;
- a 14-bit value.

The control words appear in parallel on `ctrl_q`. A command byte produces one-cycle strobes on `cmd_strobe`. SCLK, CS and MOSI are synchronized into the system clock domain, which must run at least 8 times faster than SCLK.

The frame engine is a state machine with three states:

- `FR_IDLE`: chip select is high and the drive enable is low. A detected CS fall loads the pending reply word and moves to `FR_SHIFT`.
- `FR_SHIFT`: input bits are collected on SCLK rises. The reply is shifted on those SCLK falls that follow at least one rise.
  - On the 16th rise it reports the frame and moves to `FR_DONE`.
  - If CS rises first, it discards the frame and returns to `FR_IDLE`.
- `FR_DONE`: further SCLK edges are ignored. A CS rise returns to `FR_IDLE`.

Top module: `spi_regport`

## Requirements
- R1: After reset, `spi_miso_oe` is 0, `cmd_strobe` is 0, every control word holds its `CTRL_RST` value, and the reply of the first frame is 0x0000.
- R2: A frame is 16 bits, MSB first. MOSI is taken on SCLK rising edges and MISO changes on SCLK falling edges. Frame bit 15 = 1 selects a write. Bits 14:9 hold the word index and bit 8 selects the byte (0 = low, 1 = high), so bits 14:8 form the 7-bit byte address. Bits 7:0 hold the write data.
- R3: A write to a control word (word index `CTRL_BASE` to `CTRL_BASE+N_CTRL-1`) changes only the addressed byte. The change shows on `ctrl_q` within 5 system clocks of the 16th SCLK rise, without waiting for CS to rise.
- R4: The frame after a read frame shifts out the full 16-bit word, sampled when the read frame completed. This holds whether the read named the even or the odd byte address. The frame after a write frame shifts out 0x0000.
- R5: The reply MSB is on MISO with `spi_miso_oe` = 1 after CS falls and before any SCLK edge. `spi_miso_oe` is 0 whenever CS has been high for more than 3 system clocks.
- R6: Writing the low byte of the command word (index `CMD_IDX`, byte address 30) raises `cmd_strobe` with those bits for exactly one clock. Writing its high byte raises no strobe. The command word reads 0x0000.
- R7: Output word *i* (word index *i*, byte addresses 2i and 2i+1) reads as {new-data, error, value[13:0]}. The error bit is 1 when any `diag_flags` bit is 1.
- R8: A `sens_load` pulse sets the word's new-data flag. A completed read of that word clears it. The reply to that read still shows the flag as 1.
- R9: Writes to output, diagnostic or reserved addresses change nothing. Reserved word indices read 0x0000. The diagnostic word (index `DIAG_IDX`, byte address 28) reads `diag_flags` zero-extended.
- R10: If CS rises before 16 bits have been received, the frame is dropped. Nothing is written, no new-data flag is cleared, and the next frame returns the reply that was pending before the dropped frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, idles high |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| spi_miso_oe | output | 1 | Drive enable for the MISO pad; pad is high-impedance when 0 |
| sens_load | input | N_OUT | One-cycle load strobe per output word |
| sens_data | input | N_OUT*14 | Packed 14-bit values for the output words |
| diag_flags | input | DIAG_W | Diagnostic condition flags |
| ctrl_q | output | N_CTRL*16 | Packed control words |
| cmd_strobe | output | CMD_W | One-cycle command pulses |

## Verification
The assertions check the following on every cycle:

- command pulses never last longer than one clock;
- control words change only in the cycle after a decoded frame;
- the MISO drive enable stays low while chip select is settled high and rises only after a CS fall;
- no two frame events occur back to back;
- the port leaves reset quiet.

The contents of the pipelined reply can only be shown by the bench's frame sequences. These cover:

- the byte merge into a control word;
- the new-data flag lifecycle, including loads, reads that clear it, and aborted reads that must not clear it;
- replies of zero after writes and for reserved words;
- reply preservation across an aborted frame.

// File: rtl/spi_rp_pkg.sv
package spi_rp_pkg;

    localparam int FRAME_W = 16;
    localparam int WORD_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int BADDR_W = 7;
    localparam int WIDX_W  = BADDR_W - 1;
    localparam int OUT_DW  = WORD_W - 2;

    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_SHIFT = 2'd1,
        FR_DONE  = 2'd2
    } fr_state_e;

    // Decoded command frame, MSB first
    typedef struct packed {
        logic              wr;
        logic [WIDX_W-1:0] widx;
        logic              hi;
        logic [BYTE_W-1:0] data;
    } cmd_frame_t;

endpackage

// File: rtl/spi_rp_sync.sv
module spi_rp_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic lvl
);

    logic [STAGES-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= {STAGES{RST_VAL}};
        end else begin
            sh <= {sh[STAGES-2:0], d_in};
        end
    end

    assign lvl = sh[STAGES-1];

endmodule

// File: rtl/spi_rp_frame.sv
module spi_rp_frame
    import spi_rp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_lvl,
    input  logic              sclk_lvl,
    input  logic              din_lvl,
    input  logic [WORD_W-1:0] reply_word,
    output logic              frame_valid,
    output cmd_frame_t        frame_word,
    output logic              dout,
    output logic              dout_oe
);

    localparam int             CNT_W    = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

    fr_state_e state, state_nxt;

    logic               cs_prev;
    logic               sclk_prev;
    logic               cs_fall;
    logic               sclk_rise;
    logic               sclk_fall;
    logic               last_rise;
    logic [CNT_W-1:0]   bit_cnt;
    logic [FRAME_W-2:0] rx_sh;
    logic [WORD_W-1:0]  tx_sh;

    // Edge detection in the system clock domain
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_prev   <= 1'b1;
            sclk_prev <= 1'b1;
        end else begin
            cs_prev   <= cs_lvl;
            sclk_prev <= sclk_lvl;
        end
    end

    assign cs_fall   = cs_prev & ~cs_lvl;
    assign sclk_rise = ~sclk_prev & sclk_lvl;
    assign sclk_fall = sclk_prev & ~sclk_lvl;
    assign last_rise = (state == FR_SHIFT) && !cs_lvl && sclk_rise && (bit_cnt == LAST_BIT);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FR_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            FR_IDLE: begin
                if (cs_fall) state_nxt = FR_SHIFT;
            end
            FR_SHIFT: begin
                if (cs_lvl)         state_nxt = FR_IDLE;
                else if (last_rise) state_nxt = FR_DONE;
            end
            FR_DONE: begin
                if (cs_lvl) state_nxt = FR_IDLE;
            end
            default: state_nxt = FR_IDLE;
        endcase
    end

    // Shift registers, bit counter and frame report
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt     <= '0;
            rx_sh       <= '0;
            tx_sh       <= '0;
            frame_valid <= 1'b0;
            frame_word  <= '0;
        end else begin
            frame_valid <= last_rise;
            if (last_rise) begin
                frame_word <= cmd_frame_t'({rx_sh, din_lvl});
            end
            if (state == FR_IDLE) begin
                if (cs_fall) begin
                    tx_sh   <= reply_word;
                    bit_cnt <= '0;
                    rx_sh   <= '0;
                end
            end else if (state == FR_SHIFT) begin
                if (sclk_rise) begin
                    rx_sh   <= {rx_sh[FRAME_W-3:0], din_lvl};
                    bit_cnt <= bit_cnt + 1'b1;
                end else if (sclk_fall && (bit_cnt != '0)) begin
                    // the fall before the first rise keeps the MSB in place
                    tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
                end
            end
        end
    end

    // Outputs
    always_comb begin
        dout_oe = (state != FR_IDLE);
        dout    = dout_oe & tx_sh[WORD_W-1];
    end

endmodule

// File: rtl/spi_rp_regs.sv
module spi_rp_regs
    import spi_rp_pkg::*;
#(
    parameter int N_OUT     = 4,
    parameter int N_CTRL    = 4,
    parameter int CTRL_BASE = 8,
    parameter int DIAG_IDX  = 14,
    parameter int DIAG_W    = 8,
    parameter int CMD_IDX   = 15,
    parameter int CMD_W     = 8,
    parameter logic [N_CTRL*WORD_W-1:0] CTRL_RST = '0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_valid,
    input  cmd_frame_t               frame_word,
    input  logic [N_OUT-1:0]         sens_load,
    input  logic [N_OUT*OUT_DW-1:0]  sens_data,
    input  logic [DIAG_W-1:0]        diag_flags,
    output logic [WORD_W-1:0]        reply_word,
    output logic [N_CTRL*WORD_W-1:0] ctrl_q,
    output logic [CMD_W-1:0]         cmd_strobe
);

    localparam logic [WIDX_W-1:0] CMD_W_IDX  = WIDX_W'(CMD_IDX);
    localparam logic [WIDX_W-1:0] DIAG_W_IDX = WIDX_W'(DIAG_IDX);

    logic                      wr_ev;
    logic                      rd_ev;
    logic                      err_any;
    logic [N_OUT*WORD_W-1:0]   out_words;
    logic [WORD_W-1:0]         rd_word;

    assign wr_ev   = frame_valid & frame_word.wr;
    assign rd_ev   = frame_valid & ~frame_word.wr;
    assign err_any = |diag_flags;

    // Sensor output words: value plus new-data flag
    for (genvar gi = 0; gi < N_OUT; gi++) begin : g_out
        localparam logic [WIDX_W-1:0] MY_IDX = WIDX_W'(gi);
        logic [OUT_DW-1:0] val;
        logic              nd;
        logic              rd_hit;

        assign rd_hit = rd_ev && (frame_word.widx == MY_IDX);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val <= '0;
                nd  <= 1'b0;
            end else if (sens_load[gi]) begin
                val <= sens_data[gi*OUT_DW +: OUT_DW];
                nd  <= 1'b1;
            end else if (rd_hit) begin
                nd  <= 1'b0;
            end
        end

        assign out_words[gi*WORD_W +: WORD_W] = {nd, err_any, val};
    end

    // Control words with byte-wide writes
    for (genvar gj = 0; gj < N_CTRL; gj++) begin : g_ctrl
        localparam logic [WIDX_W-1:0] MY_IDX = WIDX_W'(CTRL_BASE + gj);
        logic [WORD_W-1:0] q;
        logic              wr_hit;

        assign wr_hit = wr_ev && (frame_word.widx == MY_IDX);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= CTRL_RST[gj*WORD_W +: WORD_W];
            end else if (wr_hit) begin
                if (frame_word.hi) q[WORD_W-1:BYTE_W] <= frame_word.data;
                else               q[BYTE_W-1:0]      <= frame_word.data;
            end
        end

        assign ctrl_q[gj*WORD_W +: WORD_W] = q;
    end

    // Read selection; command and reserved words read zero
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < N_OUT; i++) begin
            if (frame_word.widx == WIDX_W'(i)) rd_word = out_words[i*WORD_W +: WORD_W];
        end
        for (int j = 0; j < N_CTRL; j++) begin
            if (frame_word.widx == WIDX_W'(CTRL_BASE + j)) rd_word = ctrl_q[j*WORD_W +: WORD_W];
        end
        if (frame_word.widx == DIAG_W_IDX) rd_word = WORD_W'(diag_flags);
    end

    // Pending reply for the next frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reply_word <= '0;
        end else if (frame_valid) begin
            reply_word <= frame_word.wr ? '0 : rd_word;
        end
    end

    // Self-clearing command pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_strobe <= '0;
        end else if (wr_ev && (frame_word.widx == CMD_W_IDX) && !frame_word.hi) begin
            cmd_strobe <= frame_word.data[CMD_W-1:0];
        end else begin
            cmd_strobe <= '0;
        end
    end

endmodule

// File: rtl/spi_regport.sv
module spi_regport
    import spi_rp_pkg::*;
#(
    parameter int N_OUT       = 4,
    parameter int N_CTRL      = 4,
    parameter int CTRL_BASE   = 8,
    parameter int DIAG_IDX    = 14,
    parameter int DIAG_W      = 8,
    parameter int CMD_IDX     = 15,
    parameter int CMD_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter logic [N_CTRL*16-1:0] CTRL_RST = {16'h0000, 16'h0000, 16'h3C00, 16'h7781}
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   spi_cs_n,
    input  logic                   spi_sclk,
    input  logic                   spi_mosi,
    output logic                   spi_miso,
    output logic                   spi_miso_oe,
    input  logic [N_OUT-1:0]       sens_load,
    input  logic [N_OUT*14-1:0]    sens_data,
    input  logic [DIAG_W-1:0]      diag_flags,
    output logic [N_CTRL*16-1:0]   ctrl_q,
    output logic [CMD_W-1:0]       cmd_strobe
);

    logic              cs_q;
    logic              sclk_q;
    logic              mosi_q;
    logic              frame_valid;
    cmd_frame_t        frame_word;
    logic [WORD_W-1:0] reply_word;

    spi_rp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
        .clk(clk), .rst_n(rst_n), .d_in(spi_cs_n), .lvl(cs_q)
    );
    spi_rp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sclk (
        .clk(clk), .rst_n(rst_n), .d_in(spi_sclk), .lvl(sclk_q)
    );
    spi_rp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
        .clk(clk), .rst_n(rst_n), .d_in(spi_mosi), .lvl(mosi_q)
    );

    spi_rp_frame u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_lvl      (cs_q),
        .sclk_lvl    (sclk_q),
        .din_lvl     (mosi_q),
        .reply_word  (reply_word),
        .frame_valid (frame_valid),
        .frame_word  (frame_word),
        .dout        (spi_miso),
        .dout_oe     (spi_miso_oe)
    );

    spi_rp_regs #(
        .N_OUT     (N_OUT),
        .N_CTRL    (N_CTRL),
        .CTRL_BASE (CTRL_BASE),
        .DIAG_IDX  (DIAG_IDX),
        .DIAG_W    (DIAG_W),
        .CMD_IDX   (CMD_IDX),
        .CMD_W     (CMD_W),
        .CTRL_RST  (CTRL_RST)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_valid (frame_valid),
        .frame_word  (frame_word),
        .sens_load   (sens_load),
        .sens_data   (sens_data),
        .diag_flags  (diag_flags),
        .reply_word  (reply_word),
        .ctrl_q      (ctrl_q),
        .cmd_strobe  (cmd_strobe)
    );

endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk #(
    parameter int N_CTRL = 4,
    parameter int CMD_W  = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cs_q,
    input logic                 frame_valid,
    input logic                 spi_miso_oe,
    input logic [N_CTRL*16-1:0] ctrl_q,
    input logic [CMD_W-1:0]     cmd_strobe
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!spi_miso_oe && (cmd_strobe == '0)));

    // R2
    single_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);

    // R3
    ctrl_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_q) |-> $past(frame_valid));

    // R5
    idle_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_q && $past(cs_q)) |-> !spi_miso_oe);

    // R5
    drive_after_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_miso_oe) |-> $past(!cs_q));

    // R6
    strobe_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_strobe != '0) |=> (cmd_strobe == '0));

endmodule

bind spi_regport spi_regport_chk #(.N_CTRL(N_CTRL), .CMD_W(CMD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_q        (cs_q),
    .frame_valid (frame_valid),
    .spi_miso_oe (spi_miso_oe),
    .ctrl_q      (ctrl_q),
    .cmd_strobe  (cmd_strobe)
);

// File: tb/test_spi_regport.sv
module test_spi_regport;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int GAP        = 6;
    localparam int N_OUT      = 4;
    localparam int N_CTRL     = 4;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 spi_cs_n;
    logic                 spi_sclk;
    logic                 spi_mosi;
    logic                 spi_miso;
    logic                 spi_miso_oe;
    logic [N_OUT-1:0]     sens_load;
    logic [N_OUT*14-1:0]  sens_data;
    logic [7:0]           diag_flags;
    logic [N_CTRL*16-1:0] ctrl_q;
    logic [7:0]           cmd_strobe;

    spi_regport i_spi_regport (
        .clk(clk), .rst_n(rst_n),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .sens_load(sens_load), .sens_data(sens_data), .diag_flags(diag_flags),
        .ctrl_q(ctrl_q), .cmd_strobe(cmd_strobe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int          n_cmp = 0;
    int          n_bad = 0;
    int          strb_cnt = 0;
    logic [7:0]  strb_val = '0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic [15:0] rx_word;
    event        rx_ev;

    task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: pops expected replies as frames complete
    initial begin
        logic [15:0] e;
        string       t;
        forever begin
            @(rx_ev);
            if (exp_q.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R4 unexpected reply: actual %h expected none", rx_word);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check16(t, rx_word, e);
            end
        end
    end

    // Command pulse counter, sampled away from the active edge
    always @(negedge clk) begin
        if (cmd_strobe != '0) begin
            strb_cnt++;
            strb_val = cmd_strobe;
        end
    end

    task automatic end_frame();
        spi_cs_n = 1'b1;
        spi_mosi = 1'b0;
        repeat (GAP) @(negedge clk);
        check16("R5 drive enable low while deselected", {15'b0, spi_miso_oe}, 16'h0000);
    endtask

    task automatic xfer(input logic [15:0] tx, input logic [15:0] exp, input string tag, input bit hold = 1'b0);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        check16("R5 drive enable before first SCLK edge", {15'b0, spi_miso_oe}, 16'h0001);
        for (int b = 15; b >= 0; b--) begin
            spi_sclk = 1'b0;
            spi_mosi = tx[b];
            repeat (HALF) @(negedge clk);
            rx_word[b] = spi_miso;
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
        end
        -> rx_ev;
        if (!hold) end_frame();
    endtask

    task automatic partial(input logic [15:0] tx, input int nbits);
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int b = 0; b < nbits; b++) begin
            spi_sclk = 1'b0;
            spi_mosi = tx[15-b];
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
        end
        end_frame();
    endtask

    task automatic load_sensor(input int idx, input logic [13:0] val);
        @(negedge clk);
        sens_load[idx] = 1'b1;
        sens_data[idx*14 +: 14] = val;
        @(negedge clk);
        sens_load = '0;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n      = 1'b0;
        spi_cs_n   = 1'b1;
        spi_sclk   = 1'b1;
        spi_mosi   = 1'b0;
        sens_load  = '0;
        sens_data  = '0;
        diag_flags = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        check16("R1 drive enable after reset", {15'b0, spi_miso_oe}, 16'h0000);
        check16("R1 control word 0 reset value", ctrl_q[15:0], 16'h7781);
        check16("R1 control word 1 reset value", ctrl_q[31:16], 16'h3C00);
        check16("R1 no command strobe", {8'h00, cmd_strobe}, 16'h0000);

        xfer(16'h1000, 16'h0000, "R1 first reply is zero");
        xfer(16'h1300, 16'h7781, "R2 R4 reply of even-address read");
        // R2 write frame, low byte of control word 0, held to check timing
        xfer(16'h905A, 16'h3C00, "R4 reply of odd-address read", 1'b1);
        check16("R3 low byte written before CS rises", ctrl_q[15:0], 16'h775A);
        end_frame();
        xfer(16'h91C3, 16'h0000, "R4 reply after write is zero");
        check16("R3 high byte merged", ctrl_q[15:0], 16'hC35A);
        check16("R3 other word untouched", ctrl_q[31:16], 16'h3C00);
        xfer(16'h1100, 16'h0000, "R4 reply after write is zero");
        xfer(16'h0000, 16'hC35A, "R2 R4 full word from odd-address read");

        load_sensor(0, 14'h1234);
        diag_flags = 8'h04;
        xfer(16'h0000, 16'h0000, "R7 output word before any load");
        xfer(16'h0100, 16'hD234, "R8 new-data and R7 error flags set");
        diag_flags = 8'h00;
        xfer(16'h80FF, 16'h5234, "R8 new-data cleared by read");
        xfer(16'h0000, 16'h0000, "R4 reply after write is zero");
        xfer(16'h0A00, 16'h1234, "R9 write to output word ignored, R7 error clear");
        diag_flags = 8'h81;
        xfer(16'h1C00, 16'h0000, "R9 reserved word reads zero");
        xfer(16'h8AAA, 16'h0081, "R9 diagnostic word zero-extended");
        check16("R9 reserved write leaves control word 0", ctrl_q[15:0], 16'hC35A);
        check16("R9 reserved write leaves control word 1", ctrl_q[31:16], 16'h3C00);

        strb_cnt = 0;
        xfer(16'h9E25, 16'h0000, "R4 reply after write is zero");
        check16("R6 one strobe cycle", 16'(strb_cnt), 16'h0001);
        check16("R6 strobe bits", {8'h00, strb_val}, 16'h0025);
        xfer(16'h9FFF, 16'h0000, "R4 reply after write is zero");
        check16("R6 high command byte gives no strobe", 16'(strb_cnt), 16'h0001);
        xfer(16'h1E00, 16'h0000, "R4 reply after write is zero");
        xfer(16'h1200, 16'h0000, "R6 command word reads zero");

        load_sensor(1, 14'h0ABC);
        partial(16'h9144, 10);
        check16("R10 aborted write dropped", ctrl_q[15:0], 16'hC35A);
        partial(16'h0200, 12);
        xfer(16'h0200, 16'h3C00, "R10 pending reply kept across aborts");
        xfer(16'h0000, 16'hCABC, "R10 aborted read left new-data set");
        xfer(16'h0200, 16'h5234, "R7 error flag follows diagnostics");
        xfer(16'h0000, 16'h4ABC, "R8 new-data cleared after read");

        repeat (20) @(negedge clk);
        check16("R4 all replies consumed", 16'(exp_q.size()), 16'h0000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule